// File: doc/BRIEF.md
# Bus Access Attribute Sequencer

This block stands between a processor's cache controllers and its one AHB master port. Each incoming request carries an address, an access kind (data, instruction or MMU table walk), a privilege flag, an atomic flag with an end-of-sequence marker, and the enable bit of the cache that owns the request. From these the block builds the AHB address-phase controls. It decides from the physical address whether the access may be cached. It encodes kind and privilege into HPROT and turns a cacheable instruction line fetch into a two-beat 128-bit incrementing burst. It also holds HLOCK across an atomic read-modify-write sequence.

Requests arrive on a valid/ready stream. A request is taken on a clock edge where `req_valid` and `req_ready` are both high, and its first beat is in the address phase from the following cycle. The requester must hold a request and all its fields steady until it is taken. Back-pressure comes from the bus: `req_ready` is low whenever `hready` is low, and also while the first beat of a burst is in the address phase. The bus side carries no handshake beyond `hready`.

Top module: `busattr_shaper`

## Requirements
- R1: `cacheable` is 1 for a transfer whose request address lies in 0x00000000–0x7FFFFFFF or 0xC0000000–0xCFFFFFFF and whose `req_cache_en` was 1. It is 0 for every other transfer.
- R2: When `req_cache_en` is 0, a request is issued as one transfer with `cacheable` 0, even if its address lies in a cacheable window.
- R3: An instruction request (`req_kind` = 01) with `cacheable` 1 is issued as an incrementing burst (`hburst` = 001, `hsize` = 100, `hwrite` = 0). It has a NONSEQ beat (`htrans` = 10) at the request address, then a SEQ beat (`htrans` = 11) at that address plus 16.
- R4: Every other request is one NONSEQ transfer with `hburst` = 000, `hsize` = `req_size` and `hwrite` = `req_write`. `hwrite` is forced to 0 for an instruction request.
- R5: `hprot` is 1100 for a user instruction, 1110 for a supervisor instruction, 1101 for user data and 1111 for supervisor data. `req_kind` 00 is data, 01 is instruction, and 11 is treated as data.
- R6: An MMU table-walk request (`req_kind` = 10) drives `hprot` = 1101 whatever `req_super` is.
- R7: `hlock` is 1 in the address phase of every transfer whose request had `req_atomic` set. After an atomic request with `req_last` 0 is taken, `hlock` stays 1 through idle cycles until the next transfer. It falls after the address phase of the atomic request that has `req_last` 1.
- R8: While `hready` is 0, a transfer in the address phase keeps `htrans`, `haddr`, `hburst`, `hsize`, `hprot`, `hwrite` and `cacheable` unchanged.
- R9: `req_ready` equals `hready`, except that it is 0 while the first beat of a burst is in the address phase. A request that is taken appears in the address phase in the next cycle.
- R10: After reset, `htrans` is IDLE (00) and `hlock` is 0.
- R11: When no transfer is pending, `htrans` is IDLE (00).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request taken on this edge when valid |
| req_addr | input | 32 | Physical byte address |
| req_kind | input | 2 | 00 data, 01 instruction, 10 MMU walk, 11 data |
| req_super | input | 1 | Supervisor privilege |
| req_atomic | input | 1 | Part of a locked sequence |
| req_last | input | 1 | Final transfer of a locked sequence |
| req_cache_en | input | 1 | Owning cache is enabled |
| req_write | input | 1 | Write transfer |
| req_size | input | 3 | HSIZE code for single transfers |
| hready | input | 1 | Bus ready; address phase completes when high |
| htrans | output | 2 | Transfer type |
| haddr | output | 32 | Address |
| hburst | output | 3 | Burst type |
| hsize | output | 3 | Transfer size |
| hprot | output | 4 | Protection attributes |
| hwrite | output | 1 | Write direction |
| hlock | output | 1 | Locked sequence |
| cacheable | output | 1 | Transfer treated as cacheable |

## Verification
The assertions take for granted that a request is held steady until taken. They also assume that an atomic sequence is made only of data or MMU requests, and that an open locked sequence is ended by an atomic request with `req_last` set before any non-atomic request comes in. The stimulus holds each request until its handshake and builds locked sequences of one to three data transfers. It may leave idle gaps inside a sequence but never mixes other requests into one. Addresses are 16-byte aligned and cluster on both edges of each window, and `hready` is dropped at random and for long runs so that held address phases and blocked bursts occur often.

// File: rtl/busattr_pkg.sv
package busattr_pkg;
  typedef enum logic [1:0] {
    TR_IDLE   = 2'b00,
    TR_BUSY   = 2'b01,
    TR_NONSEQ = 2'b10,
    TR_SEQ    = 2'b11
  } trans_e;

  typedef enum logic [2:0] {
    BU_SINGLE = 3'b000,
    BU_INCR   = 3'b001
  } burst_e;

  typedef enum logic [1:0] {
    KD_DATA  = 2'b00,
    KD_INSTR = 2'b01,
    KD_WALK  = 2'b10,
    KD_ALT   = 2'b11
  } kind_e;
endpackage

// File: rtl/busattr_window.sv
module busattr_window #(
  parameter int          ADDR_W = 32,
  parameter int          NWIN   = 2,
  parameter logic [63:0] WIN_LO [NWIN] = '{64'h0000_0000, 64'hC000_0000},
  parameter logic [63:0] WIN_HI [NWIN] = '{64'h7FFF_FFFF, 64'hCFFF_FFFF}
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit
);
  logic [NWIN-1:0] in_win;

  for (genvar g = 0; g < NWIN; g++) begin : g_win
    localparam logic [ADDR_W-1:0] LO = WIN_LO[g][ADDR_W-1:0];
    localparam logic [ADDR_W-1:0] HI = WIN_HI[g][ADDR_W-1:0];
    assign in_win[g] = (addr >= LO) && (addr <= HI);
  end

  assign hit = |in_win;
endmodule

// File: rtl/busattr_prot.sv
module busattr_prot
  import busattr_pkg::*;
(
  input  kind_e      kind,
  input  logic       supv,
  output logic [3:0] prot
);
  always_comb begin
    unique case (kind)
      KD_WALK:  prot = 4'b1101;
      KD_INSTR: prot = {2'b11, supv, 1'b0};
      default:  prot = {2'b11, supv, 1'b1};
    endcase
  end
endmodule

// File: rtl/busattr_lock.sv
module busattr_lock (
  input  logic clk,
  input  logic rst_n,
  input  logic adv,
  input  logic take,
  input  logic next_seq,
  input  logic atomic,
  input  logic last,
  output logic lock
);
  logic open_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      open_q <= 1'b0;
      lock   <= 1'b0;
    end else if (adv) begin
      if (next_seq) begin
        lock <= lock;
      end else if (take) begin
        lock   <= atomic;
        open_q <= atomic && !last;
      end else begin
        lock <= open_q;
      end
    end
  end
endmodule

// File: rtl/busattr_shaper.sv
module busattr_shaper
  import busattr_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int BEAT_BYTES = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_kind,
  input  logic              req_super,
  input  logic              req_atomic,
  input  logic              req_last,
  input  logic              req_cache_en,
  input  logic              req_write,
  input  logic [2:0]        req_size,
  input  logic              hready,
  output logic [1:0]        htrans,
  output logic [ADDR_W-1:0] haddr,
  output logic [2:0]        hburst,
  output logic [2:0]        hsize,
  output logic [3:0]        hprot,
  output logic              hwrite,
  output logic              hlock,
  output logic              cacheable
);
  localparam logic [2:0]        WIDE_SIZE = 3'($clog2(BEAT_BYTES));
  localparam logic [ADDR_W-1:0] STEP      = ADDR_W'(BEAT_BYTES);

  trans_e trans_q;
  logic   first_q;
  logic   win_hit;
  logic   cach_new;
  logic   burst_new;
  logic   take;
  logic   next_seq;
  kind_e  kind_in;
  logic [3:0] prot_new;

  assign kind_in = kind_e'(req_kind);

  busattr_window #(.ADDR_W(ADDR_W)) u_win (
    .addr (req_addr),
    .hit  (win_hit)
  );

  busattr_prot u_prot (
    .kind (kind_in),
    .supv (req_super),
    .prot (prot_new)
  );

  assign cach_new  = win_hit && req_cache_en;
  assign burst_new = cach_new && (kind_in == KD_INSTR);
  assign next_seq  = (trans_q != TR_IDLE) && first_q;
  assign req_ready = hready && !next_seq;
  assign take      = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      trans_q   <= TR_IDLE;
      first_q   <= 1'b0;
      haddr     <= '0;
      hburst    <= BU_SINGLE;
      hsize     <= '0;
      hprot     <= '0;
      hwrite    <= 1'b0;
      cacheable <= 1'b0;
    end else if (hready) begin
      if (next_seq) begin
        trans_q <= TR_SEQ;
        haddr   <= haddr + STEP;
        first_q <= 1'b0;
      end else if (take) begin
        trans_q   <= TR_NONSEQ;
        first_q   <= burst_new;
        haddr     <= req_addr;
        hburst    <= burst_new ? BU_INCR : BU_SINGLE;
        hsize     <= burst_new ? WIDE_SIZE : req_size;
        hwrite    <= req_write && (kind_in != KD_INSTR);
        hprot     <= prot_new;
        cacheable <= cach_new;
      end else begin
        trans_q <= TR_IDLE;
        first_q <= 1'b0;
      end
    end
  end

  assign htrans = trans_q;

  busattr_lock u_lock (
    .clk      (clk),
    .rst_n    (rst_n),
    .adv      (hready),
    .take     (take),
    .next_seq (next_seq),
    .atomic   (req_atomic),
    .last     (req_last),
    .lock     (hlock)
  );
endmodule

// File: rtl/busattr_shaper_chk.sv
module busattr_shaper_chk #(
  parameter int ADDR_W     = 32,
  parameter int BEAT_BYTES = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              req_atomic,
  input logic [1:0]        req_kind,
  input logic              req_super,
  input logic              hready,
  input logic [1:0]        htrans,
  input logic [ADDR_W-1:0] haddr,
  input logic [2:0]        hburst,
  input logic [3:0]        hprot,
  input logic              hlock,
  input logic              cacheable
);
  a_r9_ready_needs_hready: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> hready);

  a_r3_second_beat: assert property (@(posedge clk) disable iff (!rst_n)
    (htrans == 2'b10 && hburst == 3'b001 && hready) |=>
      (htrans == 2'b11 && haddr == $past(haddr) + ADDR_W'(BEAT_BYTES)));

  a_r1_burst_cacheable: assert property (@(posedge clk) disable iff (!rst_n)
    (htrans != 2'b00 && hburst == 3'b001) |-> (cacheable && hprot[0] == 1'b0));

  a_r8_hold_on_wait: assert property (@(posedge clk) disable iff (!rst_n)
    (htrans != 2'b00 && !hready) |=>
      ($stable(htrans) && $stable(haddr) && $stable(hprot) && $stable(cacheable)));

  a_r7_atomic_locks: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_atomic) |=> hlock);

  a_r6_walk_prot: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_kind == 2'b10) |=> (hprot == 4'b1101));

  a_r5_priv_bit: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_kind != 2'b10) |=> (hprot[1] == $past(req_super)));

  a_r9_accept_starts: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (htrans == 2'b10));
endmodule

bind busattr_shaper busattr_shaper_chk #(.ADDR_W(ADDR_W), .BEAT_BYTES(BEAT_BYTES)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .req_atomic (req_atomic),
  .req_kind   (req_kind),
  .req_super  (req_super),
  .hready     (hready),
  .htrans     (htrans),
  .haddr      (haddr),
  .hburst     (hburst),
  .hprot      (hprot),
  .hlock      (hlock),
  .cacheable  (cacheable)
);

// File: tb/test_busattr_shaper.sv
module test_busattr_shaper;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_ready;
  logic [31:0] req_addr = '0;
  logic [1:0]  req_kind = '0;
  logic        req_super = 1'b0, req_atomic = 1'b0, req_last = 1'b0;
  logic        req_cache_en = 1'b0, req_write = 1'b0;
  logic [2:0]  req_size = '0;
  logic        hready = 1'b1;
  logic [1:0]  htrans;
  logic [31:0] haddr;
  logic [2:0]  hburst, hsize;
  logic [3:0]  hprot;
  logic        hwrite, hlock, cacheable;

  always #4 clk = ~clk;

  busattr_shaper i_busattr_shaper (.*);

  typedef struct {
    logic [31:0] a; logic [1:0] t; logic [2:0] b; logic [2:0] s;
    logic [3:0] p; logic w; logic l; logic c; logic first;
  } beat_t;

  beat_t q[$];
  int ncmp = 0, nerr = 0;
  bit finished = 1'b0;
  bit open_m = 1'b0;
  bit have_req = 1'b0;
  int atomic_left = 0;
  int stall_run = 0;

  task automatic chk(string tag, string fld, logic [31:0] act, logic [31:0] exp);
    ncmp++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s %s: actual %h expected %h at %0t", tag, fld, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] pick_addr();
    logic [31:0] edges [8] = '{32'h7FFF_FFF0, 32'h8000_0000, 32'hBFFF_FFF0, 32'hC000_0000,
                               32'hCFFF_FFF0, 32'hD000_0000, 32'h0000_0000, 32'hFFFF_FFF0};
    if ($urandom_range(0, 1) == 0) return edges[$urandom_range(0, 7)];
    return {$urandom()} & 32'hFFFF_FFF0;
  endfunction

  function automatic logic [3:0] exp_prot(logic [1:0] k, logic s);
    if (k == 2'b10) return 4'b1101;
    if (k == 2'b01) return s ? 4'b1110 : 4'b1100;
    return s ? 4'b1111 : 4'b1101;
  endfunction

  task automatic new_request();
    req_addr     = pick_addr();
    req_super    = 1'($urandom_range(0, 1));
    req_cache_en = ($urandom_range(0, 3) != 0);
    req_size     = 3'($urandom_range(0, 2));
    req_write    = 1'($urandom_range(0, 1));
    if (atomic_left == 0 && $urandom_range(0, 9) == 0) atomic_left = $urandom_range(1, 3);
    if (atomic_left > 0) begin
      req_kind   = ($urandom_range(0, 3) == 0) ? 2'b10 : 2'b00;
      req_atomic = 1'b1;
      req_last   = (atomic_left == 1);
    end else begin
      req_kind   = 2'($urandom_range(0, 3));
      req_atomic = 1'b0;
      req_last   = 1'b0;
    end
    have_req = 1'b1;
  endtask

  task automatic push_expected();
    beat_t bt;
    logic win;
    win = (req_addr <= 32'h7FFF_FFFF) || (req_addr >= 32'hC000_0000 && req_addr <= 32'hCFFF_FFFF);
    bt.c = win && req_cache_en;
    bt.p = exp_prot(req_kind, req_super);
    bt.l = req_atomic;
    bt.a = req_addr;
    bt.t = 2'b10;
    if (bt.c && req_kind == 2'b01) begin
      bt.b = 3'b001; bt.s = 3'b100; bt.w = 1'b0; bt.first = 1'b1;
      q.push_back(bt);
      bt.a = req_addr + 32'd16; bt.t = 2'b11; bt.first = 1'b0;
      q.push_back(bt);
    end else begin
      bt.b = 3'b000; bt.s = req_size; bt.w = req_write && (req_kind != 2'b01); bt.first = 1'b0;
      q.push_back(bt);
    end
    open_m = req_atomic && !req_last;
  endtask

  initial begin : watchdog
    #1_500_000;
    if (!finished) begin
      nerr++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", ncmp, nerr);
      $finish;
    end
  end

  initial begin : main
    repeat (4) @(negedge clk);
    chk("R10", "htrans", 32'(htrans), 32'h0);
    chk("R10", "hlock", 32'(hlock), 32'h0);
    rst_n = 1'b1;
    for (int cyc = 0; cyc < 6000; cyc++) begin
      @(negedge clk);
      if (q.size() > 0) begin
        chk("R3/R4/R9", "htrans", 32'(htrans), 32'(q[0].t));
        chk("R3/R4", "haddr", haddr, q[0].a);
        chk("R3/R4", "hburst", 32'(hburst), 32'(q[0].b));
        chk("R3/R4", "hsize", 32'(hsize), 32'(q[0].s));
        chk("R4", "hwrite", 32'(hwrite), 32'(q[0].w));
        chk("R5/R6", "hprot", 32'(hprot), 32'(q[0].p));
        chk("R1/R2", "cacheable", 32'(cacheable), 32'(q[0].c));
        chk("R7", "hlock", 32'(hlock), 32'(q[0].l));
      end else begin
        chk("R11", "htrans", 32'(htrans), 32'h0);
        chk("R7", "hlock idle", 32'(hlock), 32'(open_m));
      end
      if (stall_run > 0) begin
        stall_run--; hready = 1'b0;
      end else if ($urandom_range(0, 60) == 0) begin
        stall_run = $urandom_range(3, 8); hready = 1'b0;
      end else begin
        hready = ($urandom_range(0, 3) != 0);
      end
      if (!have_req && $urandom_range(0, 4) != 0) new_request();
      req_valid = have_req;
      #1;
      chk("R8/R9", "req_ready", 32'(req_ready),
          32'(hready && !(q.size() > 0 && q[0].first)));
      if (hready && q.size() > 0) void'(q.pop_front());
      if (req_valid && req_ready) begin
        push_expected();
        have_req = 1'b0;
        if (atomic_left > 0) atomic_left--;
      end
    end
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", ncmp, nerr);
    $finish;
  end
endmodule